// File: doc/BRIEF.md
# Serial EEPROM Access Port with Word Reader and Pin Arbitration

This block connects a network controller's register space to an external serial EEPROM on a four-wire SPI link. It offers two 32-bit registers. The pin register lets software drive the clock, chip-select and data-out wires directly and read back the data-in wire, once it has been granted ownership of the link. The word register starts a self-timed read that fetches one 16-bit word from the EEPROM and raises a completion flag.

Only one agent owns the pins at a time. Software gains ownership by setting a request bit. The grant follows only when the word reader is idle. While the grant is held, the reader refuses to start. If software holds the grant but leaves the wires untouched for a programmable number of clock cycles, the block withdraws the request by itself.

The pin register also reports the EEPROM-present strap and the 4-bit size strap. A decoded capacity output gives the size in kilobytes.

Top module: `nic_ee_port`

## Requirements
- R1: After reset, the pin register reads with only bit 1 (chip-select, high = deselected) set, apart from the strap fields. The word register reads 0. The pins sit at chip-select high and clock low.
- R2: Bit 8 of the pin register shows the present strap, and bits 14:11 show the size strap. `dev_kbytes_o` is 16 for size code 7, 32 for code 8 and 0 for every other code.
- R3: Writing the word register with bit 0 set starts a read of the word address in bits 15:2. The reader sends opcode 0x03 and then a 16-bit byte address equal to twice the word address, MSB first in SPI mode 0 (clock idles low, data sampled on the rising edge). It then receives two bytes. The first received byte goes to bits 23:16 and the second to bits 31:24, so byte 2n is the low byte of word n.
- R4: An accepted start clears DONE (bit 1) on the following cycle. DONE sets in the same cycle that the data field receives the new word. The data field changes at no other time.
- R5: GNT (bit 7) is high exactly while REQ (bit 6) is set and the reader is idle. A request written during a read is granted once that read ends.
- R6: While GNT is high, the clock pin follows bit 0, the chip-select pin follows bit 1 (0 selects the device) and the data-out pin follows bit 2, and bit 3 shows the EEPROM data line. Without GNT, bit 3 reads 0 and the reader owns the pins.
- R7: A start written while GNT is high is ignored. The pins, DONE, the address field and the data field are left unchanged.
- R8: With GNT held and no written change to the clock, chip-select or data-out bits for IDLE_CYCLES consecutive cycles, REQ clears and GNT falls. Any such change restarts the count.
- R9: A start written while a read is in progress is ignored, and only the first read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Write target: 0 pin register, 1 word register |
| reg_wdata_i | input | 32 | Write data |
| ctrl_rdata_o | output | 32 | Pin register read value |
| read_rdata_o | output | 32 | Word register read value |
| ee_present_i | input | 1 | EEPROM-present strap |
| ee_size_i | input | 4 | Size code strap |
| dev_kbytes_o | output | 6 | Decoded capacity in KB, 0 if unsupported |
| ee_sck_o | output | 1 | SPI clock |
| ee_cs_no | output | 1 | SPI chip select, active low |
| ee_si_o | output | 1 | Serial data to EEPROM |
| ee_so_i | input | 1 | Serial data from EEPROM |

## Verification
Word reads are run at addresses 0, 1, the top of the 14-bit range and the alternating patterns 0x2AAA and 0x1555. The modelled EEPROM returns a different byte at every address, so swapped bytes, a wrong doubling of the address or a bit-order error each yield a wrong word. A software bit-banged read of the same model checks the other path to the pins and the SO bit. Collisions are covered by a start written during a read, a start written under grant, and a request raised during a read. The timeout is checked both with the pins left idle and with a pin change that must restart the count.

// File: rtl/nic_ee_pkg.sv
package nic_ee_pkg;
  // pin register bit positions
  localparam int CTL_SCK   = 0;
  localparam int CTL_CS    = 1;
  localparam int CTL_SI    = 2;
  localparam int CTL_SO    = 3;
  localparam int CTL_REQ   = 6;
  localparam int CTL_GNT   = 7;
  localparam int CTL_PRES  = 8;
  localparam int CTL_SZ_LO = 11;
  localparam int SZ_W      = 4;

  // word register bit positions
  localparam int RD_GO      = 0;
  localparam int RD_FIN     = 1;
  localparam int RD_ADDR_LO = 2;
  localparam int RD_DATA_LO = 16;

  localparam logic [7:0] SPI_READ_OP = 8'h03;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_SHIFT,
    ENG_FIN
  } eng_state_e;

  function automatic logic [5:0] size_kbytes(input logic [SZ_W-1:0] code);
    case (code)
      4'd7:    return 6'd16;
      4'd8:    return 6'd32;
      default: return 6'd0;
    endcase
  endfunction
endpackage

// File: rtl/nic_ee_spi_rd.sv
module nic_ee_spi_rd
  import nic_ee_pkg::*;
#(
  parameter int HALF_CYC = 2,
  parameter int ADDR_W   = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] waddr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [15:0]       word_o,
  output logic              sck_o,
  output logic              cs_no,
  output logic              si_o,
  input  logic              so_i
);
  localparam int FRAME = 40;  // opcode + address + two data bytes
  localparam int CNT_W = $clog2(FRAME);
  localparam int DIV_W = $clog2(HALF_CYC + 1);

  eng_state_e       state_q;
  logic [FRAME-1:0] tx_q;
  logic [15:0]      rx_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] bit_q;
  logic [15:0]      baddr;

  assign baddr  = 16'({waddr_i, 1'b0});
  assign busy_o = (state_q != ENG_IDLE);
  assign done_o = (state_q == ENG_FIN);
  assign si_o   = (state_q == ENG_SHIFT) & tx_q[FRAME-1];
  // first byte received is the low byte
  assign word_o = {rx_q[7:0], rx_q[15:8]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENG_IDLE;
      tx_q    <= '0;
      rx_q    <= '0;
      div_q   <= '0;
      bit_q   <= '0;
      sck_o   <= 1'b0;
      cs_no   <= 1'b1;
    end else begin
      case (state_q)
        ENG_IDLE: begin
          if (start_i) begin
            tx_q    <= {SPI_READ_OP, baddr, 16'h0000};
            cs_no   <= 1'b0;
            sck_o   <= 1'b0;
            div_q   <= '0;
            bit_q   <= '0;
            state_q <= ENG_SHIFT;
          end
        end
        ENG_SHIFT: begin
          if (div_q == DIV_W'(HALF_CYC - 1)) begin
            div_q <= '0;
            if (!sck_o) begin
              sck_o <= 1'b1;
              rx_q  <= {rx_q[14:0], so_i};
            end else begin
              sck_o <= 1'b0;
              if (bit_q == CNT_W'(FRAME - 1)) begin
                state_q <= ENG_FIN;
              end else begin
                bit_q <= bit_q + 1'b1;
                tx_q  <= tx_q << 1;
              end
            end
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        ENG_FIN: begin
          cs_no   <= 1'b1;
          state_q <= ENG_IDLE;
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nic_ee_idle_timer.sv
module nic_ee_idle_timer #(
  parameter int LIMIT = 500_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic act_i,
  output logic expire_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = arm_i & ~act_i & (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!arm_i || act_i || expire_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/nic_ee_port.sv
module nic_ee_port
  import nic_ee_pkg::*;
#(
  parameter int IDLE_CYCLES = 500_000_000,
  parameter int SCK_HALF    = 2,
  parameter int WADDR_W     = 14
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic        reg_sel_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] ctrl_rdata_o,
  output logic [31:0] read_rdata_o,
  input  logic        ee_present_i,
  input  logic [3:0]  ee_size_i,
  output logic [5:0]  dev_kbytes_o,
  output logic        ee_sck_o,
  output logic        ee_cs_no,
  output logic        ee_si_o,
  input  logic        ee_so_i
);
  logic               sw_sck_q, sw_cs_nq, sw_si_q, req_q;
  logic [WADDR_W-1:0] rd_addr_q;
  logic               rd_done_q;
  logic [15:0]        rd_data_q;

  logic        gnt, ctrl_wr, word_wr, start_ok, pin_act, expire;
  logic        eng_busy, eng_done, eng_sck, eng_cs_n, eng_si;
  logic [15:0] eng_word;

  assign ctrl_wr  = reg_we_i & ~reg_sel_i;
  assign word_wr  = reg_we_i & reg_sel_i;
  assign gnt      = req_q & ~eng_busy;
  assign start_ok = word_wr & reg_wdata_i[RD_GO] & ~req_q & ~eng_busy;
  assign pin_act  = ctrl_wr & gnt &
                    ((reg_wdata_i[CTL_SCK] != sw_sck_q) |
                     (reg_wdata_i[CTL_CS]  != sw_cs_nq) |
                     (reg_wdata_i[CTL_SI]  != sw_si_q));

  nic_ee_spi_rd #(
    .HALF_CYC (SCK_HALF),
    .ADDR_W   (WADDR_W)
  ) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_ok),
    .waddr_i (reg_wdata_i[RD_ADDR_LO +: WADDR_W]),
    .busy_o  (eng_busy),
    .done_o  (eng_done),
    .word_o  (eng_word),
    .sck_o   (eng_sck),
    .cs_no   (eng_cs_n),
    .si_o    (eng_si),
    .so_i    (ee_so_i)
  );

  nic_ee_idle_timer #(
    .LIMIT (IDLE_CYCLES)
  ) u_idle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (gnt),
    .act_i    (pin_act),
    .expire_o (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_sck_q <= 1'b0;
      sw_cs_nq <= 1'b1;
      sw_si_q  <= 1'b0;
      req_q    <= 1'b0;
    end else if (ctrl_wr) begin
      sw_sck_q <= reg_wdata_i[CTL_SCK];
      sw_cs_nq <= reg_wdata_i[CTL_CS];
      sw_si_q  <= reg_wdata_i[CTL_SI];
      req_q    <= reg_wdata_i[CTL_REQ];
    end else if (expire) begin
      req_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_addr_q <= '0;
      rd_done_q <= 1'b0;
      rd_data_q <= '0;
    end else if (start_ok) begin
      rd_addr_q <= reg_wdata_i[RD_ADDR_LO +: WADDR_W];
      rd_done_q <= 1'b0;
    end else if (eng_done) begin
      rd_data_q <= eng_word;
      rd_done_q <= 1'b1;
    end
  end

  // pin ownership
  assign ee_sck_o = gnt ? sw_sck_q : eng_sck;
  assign ee_cs_no = gnt ? sw_cs_nq : eng_cs_n;
  assign ee_si_o  = gnt ? sw_si_q  : eng_si;

  assign dev_kbytes_o = size_kbytes(ee_size_i);

  always_comb begin
    ctrl_rdata_o                         = '0;
    ctrl_rdata_o[CTL_SCK]                = sw_sck_q;
    ctrl_rdata_o[CTL_CS]                 = sw_cs_nq;
    ctrl_rdata_o[CTL_SI]                 = sw_si_q;
    ctrl_rdata_o[CTL_SO]                 = gnt & ee_so_i;
    ctrl_rdata_o[CTL_REQ]                = req_q;
    ctrl_rdata_o[CTL_GNT]                = gnt;
    ctrl_rdata_o[CTL_PRES]               = ee_present_i;
    ctrl_rdata_o[CTL_SZ_LO +: SZ_W]      = ee_size_i;
  end

  always_comb begin
    read_rdata_o                           = '0;
    read_rdata_o[RD_FIN]                   = rd_done_q;
    read_rdata_o[RD_ADDR_LO +: WADDR_W]    = rd_addr_q;
    read_rdata_o[RD_DATA_LO +: 16]         = rd_data_q;
  end
endmodule

// File: rtl/nic_ee_port_chk.sv
module nic_ee_port_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [31:0] ctrl_rdata_o,
  input logic [31:0] read_rdata_o,
  input logic [5:0]  dev_kbytes_o,
  input logic        ee_sck_o,
  input logic        ee_cs_no,
  input logic        ee_si_o
);
  // R6
  gnt_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rdata_o[7] |-> (ee_sck_o == ctrl_rdata_o[0] && ee_cs_no == ctrl_rdata_o[1]
                         && ee_si_o == ctrl_rdata_o[2]));

  // R6
  so_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_rdata_o[7] |-> !ctrl_rdata_o[3]);

  // R5
  gnt_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rdata_o[7] |-> ctrl_rdata_o[6]);

  // R4
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(read_rdata_o[1]) |-> $stable(read_rdata_o[31:16]));

  // R4
  busy_not_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_rdata_o[7] && !ee_cs_no) |-> !read_rdata_o[1]);

  // R3
  idle_clk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_rdata_o[7] && ee_cs_no) |-> !ee_sck_o);

  // R8
  req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ctrl_rdata_o[6]) && !$past(reg_we_i)) |-> $past(ctrl_rdata_o[7]));

  // R2
  size_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_kbytes_o == 6'd0 || dev_kbytes_o == 6'd16 || dev_kbytes_o == 6'd32));
endmodule

bind nic_ee_port nic_ee_port_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_we_i     (reg_we_i),
  .ctrl_rdata_o (ctrl_rdata_o),
  .read_rdata_o (read_rdata_o),
  .dev_kbytes_o (dev_kbytes_o),
  .ee_sck_o     (ee_sck_o),
  .ee_cs_no     (ee_cs_no),
  .ee_si_o      (ee_si_o)
);

// File: tb/nic_ee_port_test.sv
`timescale 1ns/1ps
module nic_ee_port_test;
  localparam int IDLE = 64;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic        reg_sel_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] ctrl_rdata_o, read_rdata_o;
  logic        ee_present_i = 1'b1;
  logic [3:0]  ee_size_i = 4'd7;
  logic [5:0]  dev_kbytes_o;
  logic        ee_sck_o, ee_cs_no, ee_si_o, ee_so_i;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  nic_ee_port #(.IDLE_CYCLES(IDLE), .SCK_HALF(2), .WADDR_W(14)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i),
    .reg_wdata_i(reg_wdata_i), .ctrl_rdata_o(ctrl_rdata_o), .read_rdata_o(read_rdata_o),
    .ee_present_i(ee_present_i), .ee_size_i(ee_size_i), .dev_kbytes_o(dev_kbytes_o),
    .ee_sck_o(ee_sck_o), .ee_cs_no(ee_cs_no), .ee_si_o(ee_si_o), .ee_so_i(ee_so_i)
  );

  // ---------------- EEPROM model ----------------
  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    logic [7:0] t;
    t = a[7:0] * 8'd37;
    return t ^ (a[15:8] + 8'h5a);
  endfunction

  int          ee_bits = 0;
  logic [23:0] ee_hdr = '0;
  logic [15:0] ee_a = '0;
  logic [7:0]  ee_cmd = '0;
  logic        so_r = 1'b0;
  logic        so_force_en = 1'b0;
  logic        so_force_val = 1'b0;

  assign ee_so_i = so_force_en ? so_force_val : so_r;

  always @(posedge ee_sck_o) begin
    if (!ee_cs_no) begin
      ee_hdr = {ee_hdr[22:0], ee_si_o};
      ee_bits = ee_bits + 1;
      if (ee_bits == 24) begin
        ee_a   = ee_hdr[15:0];
        ee_cmd = ee_hdr[23:16];
      end
    end
  end

  always @(negedge ee_sck_o) begin
    if (!ee_cs_no && ee_bits >= 24) begin
      int k;
      logic [7:0] b;
      k = ee_bits - 24;
      b = mem_byte(ee_a + 16'(k / 8));
      so_r = b[7 - (k % 8)];
    end
  end

  always @(posedge ee_cs_no) ee_bits = 0;

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  function automatic logic [31:0] cw(input logic req, input logic si, input logic cs, input logic sck);
    return (32'(req) << 6) | (32'(si) << 2) | (32'(cs) << 1) | 32'(sck);
  endfunction

  // ---------------- scoreboard ----------------
  logic [15:0] exp_q[$];
  logic        prev_done = 1'b0;

  always @(negedge clk) begin
    if (rst_ni && read_rdata_o[1] && !prev_done) begin
      if (exp_q.size() == 0) begin
        chk("R3 unexpected completion", 32'h1, 32'h0);
      end else begin
        chk("R3 word data", 32'(read_rdata_o[31:16]), 32'(exp_q.pop_front()));
      end
    end
    prev_done = read_rdata_o[1];
  end

  task automatic start_read(input logic [13:0] wa);
    logic [15:0] ba;
    ba = 16'({wa, 1'b0});
    exp_q.push_back({mem_byte(ba + 16'd1), mem_byte(ba)});
    wr(1'b1, (32'(wa) << 2) | 32'h1);
    // R4: DONE cleared right after an accepted start
    chk("R4 done cleared", 32'(read_rdata_o[1]), 32'h0);
    chk("R3 chip selected", 32'(ee_cs_no), 32'h0);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 2000 && !read_rdata_o[1]; i++) @(negedge clk);
    chk("R4 done set", 32'(read_rdata_o[1]), 32'h1);
  endtask

  task automatic issue_read(input logic [13:0] wa);
    start_read(wa);
    wait_done();
    chk("R3 opcode", 32'(ee_cmd), 32'h03);
    chk("R3 byte address", 32'(ee_a), 32'({wa, 1'b0}));
    chk("R3 address field", 32'(read_rdata_o[15:2]), 32'(wa));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] snap;
    logic [23:0] hdr;
    logic [7:0]  got;
    int          bad;

    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 pin reg", ctrl_rdata_o, 32'h0000_0100 | (32'd7 << 11) | 32'h2);
    chk("R1 word reg", read_rdata_o, 32'h0);
    chk("R1 pins", {29'b0, ee_cs_no, ee_sck_o, ee_si_o}, 32'h4);
    // R2
    chk("R2 kb code7", 32'(dev_kbytes_o), 32'd16);
    ee_size_i = 4'd8; #1;
    chk("R2 kb code8", 32'(dev_kbytes_o), 32'd32);
    chk("R2 size field", 32'(ctrl_rdata_o[14:11]), 32'd8);
    ee_size_i = 4'd5; ee_present_i = 1'b0; #1;
    chk("R2 kb unsupported", 32'(dev_kbytes_o), 32'd0);
    chk("R2 present bit", 32'(ctrl_rdata_o[8]), 32'd0);
    ee_size_i = 4'd7; ee_present_i = 1'b1;

    // R3 word reads
    issue_read(14'h0000);
    issue_read(14'h0001);
    issue_read(14'h3fff);
    issue_read(14'h2aaa);
    issue_read(14'h1555);
    issue_read(14'h1234);

    // R9 second start during a read is ignored
    start_read(14'h0042);
    wr(1'b1, (32'h0077 << 2) | 32'h1);
    wait_done();
    chk("R9 address kept", 32'(read_rdata_o[15:2]), 32'h0042);
    repeat (200) @(negedge clk);
    chk("R9 no second done", 32'(exp_q.size()), 32'd0);

    // R6 SO masked without grant
    so_force_en = 1'b1; so_force_val = 1'b1; #1;
    chk("R6 SO masked", 32'(ctrl_rdata_o[3]), 32'h0);
    wr(1'b0, cw(1, 0, 1, 0));
    chk("R5 grant when idle", 32'(ctrl_rdata_o[7:6]), 32'h3);
    chk("R6 SO visible", 32'(ctrl_rdata_o[3]), 32'h1);
    so_force_en = 1'b0;
    wr(1'b0, cw(1, 1, 1, 1));
    chk("R6 pins follow", {29'b0, ee_sck_o, ee_cs_no, ee_si_o}, 32'h7);

    // R7 start under grant ignored
    snap = read_rdata_o;
    wr(1'b1, (32'h0005 << 2) | 32'h1);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ee_cs_no !== 1'b1 || ee_sck_o !== 1'b1) bad++;
    end
    chk("R7 pins untouched", 32'(bad), 32'd0);
    chk("R7 word reg unchanged", read_rdata_o, snap);

    // R6 bit-banged read of byte 0x0123
    wr(1'b0, cw(1, 0, 1, 0));
    hdr = {8'h03, 16'h0123};
    for (int i = 23; i >= 0; i--) begin
      wr(1'b0, cw(1, hdr[i], 0, 0));
      wr(1'b0, cw(1, hdr[i], 0, 1));
    end
    got = '0;
    for (int i = 7; i >= 0; i--) begin
      wr(1'b0, cw(1, 0, 0, 0));
      wr(1'b0, cw(1, 0, 0, 1));
      got[i] = ctrl_rdata_o[3];
    end
    wr(1'b0, cw(1, 0, 1, 0));
    chk("R6 bit-bang byte", 32'(got), 32'(mem_byte(16'h0123)));

    // R5 request during a read
    wr(1'b0, cw(0, 0, 1, 0));
    start_read(14'h0100);
    wr(1'b0, cw(1, 0, 1, 0));
    chk("R5 no grant while busy", 32'(ctrl_rdata_o[7:6]), 32'h1);
    wait_done();
    @(negedge clk);
    chk("R5 grant after read", 32'(ctrl_rdata_o[7]), 32'h1);

    // R8 timeout with idle pins
    wr(1'b0, cw(0, 0, 1, 0));
    wr(1'b0, cw(1, 0, 1, 0));
    repeat (IDLE - 4) @(negedge clk);
    chk("R8 req held", 32'(ctrl_rdata_o[6]), 32'h1);
    repeat (8) @(negedge clk);
    chk("R8 req cleared", 32'(ctrl_rdata_o[7:6]), 32'h0);

    // R8 activity restarts the count
    wr(1'b0, cw(1, 0, 1, 0));
    repeat (40) @(negedge clk);
    wr(1'b0, cw(1, 1, 1, 0));
    repeat (40) @(negedge clk);
    chk("R8 restart holds req", 32'(ctrl_rdata_o[6]), 32'h1);
    repeat (30) @(negedge clk);
    chk("R8 restart then expire", 32'(ctrl_rdata_o[6]), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule